// File: doc/BRIEF.md
# Mains Phase-Tracking Period Corrector

This block keeps a free-running timer locked in phase to the AC line. The line cycle is split into six equal timer periods. A timer tick of 2 MHz gives 6666 ticks per period on a 50 Hz line and 5555 ticks on a 60 Hz line. The timer reloads at minus five, so the nominal compare value is the tick count less five: 6661 at 50 Hz and 5550 at 60 Hz.

On every rising zero-crossing, the surrounding logic presents the timer value it captured, together with the position where that edge should have landed. The block forms a signed phase error from the two and divides it by sixteen with an arithmetic shift. It limits the result to less than half a percent of the nominal period and adds it to the nominal value. The result is held in a staging register.

Zero-crossings bear no fixed relation to the timer's compare events. For that reason the staged period moves into the compare register only on the strobe that marks the start of a timer cycle, and never between two cycle starts.

Top module: `mainsPeriodCorrector`

## Requirements
- R1: From reset until the first cycle-start strobe, `comparePeriod` shows the nominal value of the mode currently selected.
- R2: `sel60Hz`=0 selects the 50 Hz nominal of 6661. `sel60Hz`=1 selects the 60 Hz nominal of 5550.
- R3: The phase error is `captureValue - edgePosition`, taken modulo 2^16 and read as a 16-bit two's complement number. This holds when the subtraction wraps around zero.
- R4: The correction is the error shifted right arithmetically by four bits, which rounds toward minus infinity. Errors of -1 and -17 give -1 and -2. An error of 15 gives 0.
- R5: The correction is clamped to the range -33..+33 in 50 Hz mode and -27..+27 in 60 Hz mode.
- R6: A capture strobe stores nominal + clamped correction in the staging register. The nominal and the limit are those of the mode present in the capture cycle.
- R7: `comparePeriod` changes only on the clock edge after a cycle-start strobe. Captures and mode changes alone leave it unchanged once it has been loaded.
- R8: When a capture and a cycle start occur in the same cycle, the compare register takes the staged value from before that capture. The new value appears at the following cycle start.
- R9: If no capture has occurred since reset, a cycle start loads the nominal value of the mode present at that moment. Among several captures between two cycle starts, the last one is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer-domain clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sel60Hz | input | 1 | Mains mode: 0 = 50 Hz, 1 = 60 Hz |
| captureValid | input | 1 | One-cycle strobe marking a rising zero-crossing capture |
| captureValue | input | 16 | Timer value captured at the zero-crossing |
| edgePosition | input | 16 | Timer value at which the zero-crossing is expected |
| cycleStart | input | 1 | One-cycle strobe at the start of compare-event handling |
| comparePeriod | output | 16 | Period value applied to the timer compare register |

## Verification
The bench targets the cases where the arithmetic fails quietly. Errors of -1 and -17 expose a logical shift or a divide that rounds toward zero: a logical shift would give a huge positive step, and a rounding divide would give 0 and -1. Errors that land exactly on the limit, one step past it, and far past it in both modes catch an off-by-one or a swapped limit. A wrapped subtraction catches a design that treats the error as unsigned. The bench also issues a capture and a cycle start together, captures without any transfer, and changes the mode after loading. A design that forwards the new value or writes the compare register early would show the wrong period at the port.

// File: rtl/mainsPeriodPkg.sv
package mainsPeriodPkg;

  // Strobes from control to datapath, one set per clock cycle.
  typedef struct packed {
    logic captureEn;          // store a freshly corrected period
    logic transferEn;         // copy staging register into compare register
    logic stagedFromNominal;  // no capture yet: staging reads as nominal
    logic compareFromNominal; // no transfer yet: output reads as nominal
  } pcStrobes_t;

  // Clamp limit in ticks: largest integer strictly below perMille/1000 of nominal.
  function automatic int clampLimit(input int nominal, input int perMille);
    int prod;
    prod = nominal * perMille;
    if (prod % 1000 == 0) return prod / 1000 - 1;
    return prod / 1000;
  endfunction

endpackage

// File: rtl/mainsPeriodControl.sv
module mainsPeriodControl
  import mainsPeriodPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       captureValid,
  input  logic       cycleStart,
  output pcStrobes_t strobes
);

  logic capturedQ;
  logic loadedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capturedQ <= 1'b0;
      loadedQ   <= 1'b0;
    end else begin
      if (captureValid) capturedQ <= 1'b1;
      if (cycleStart)   loadedQ   <= 1'b1;
    end
  end

  always_comb begin
    strobes.captureEn          = captureValid;
    strobes.transferEn         = cycleStart;
    strobes.stagedFromNominal  = !capturedQ;
    strobes.compareFromNominal = !loadedQ;
  end

  AST_CAPTURE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    captureValid |=> !strobes.stagedFromNominal); // R9

  AST_LOAD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.compareFromNominal |=> !strobes.compareFromNominal); // R1

endmodule

// File: rtl/mainsPeriodDatapath.sv
module mainsPeriodDatapath
  import mainsPeriodPkg::*;
#(
  parameter int WIDTH         = 16,
  parameter int TICKS_50      = 6666,
  parameter int TICKS_60      = 5555,
  parameter int RELOAD_OFFSET = 5,
  parameter int GAIN_SHIFT    = 4,
  parameter int CLAMP_PER_MILLE = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel60Hz,
  input  pcStrobes_t       strobes,
  input  logic [WIDTH-1:0] captureValue,
  input  logic [WIDTH-1:0] edgePosition,
  output logic [WIDTH-1:0] comparePeriod
);

  localparam int NOM_50 = TICKS_50 - RELOAD_OFFSET;
  localparam int NOM_60 = TICKS_60 - RELOAD_OFFSET;
  localparam int LIM_50 = clampLimit(NOM_50, CLAMP_PER_MILLE);
  localparam int LIM_60 = clampLimit(NOM_60, CLAMP_PER_MILLE);
  localparam int LO_BOUND = ((NOM_60 - LIM_60) < (NOM_50 - LIM_50)) ? (NOM_60 - LIM_60) : (NOM_50 - LIM_50);
  localparam int HI_BOUND = ((NOM_60 + LIM_60) > (NOM_50 + LIM_50)) ? (NOM_60 + LIM_60) : (NOM_50 + LIM_50);

  localparam logic [WIDTH-1:0]        NOM_50_W = WIDTH'(NOM_50);
  localparam logic [WIDTH-1:0]        NOM_60_W = WIDTH'(NOM_60);
  localparam logic signed [WIDTH-1:0] LIM_50_S = WIDTH'(LIM_50);
  localparam logic signed [WIDTH-1:0] LIM_60_S = WIDTH'(LIM_60);

  logic [WIDTH-1:0]        nominalNow;
  logic signed [WIDTH-1:0] limitNow;
  logic signed [WIDTH-1:0] phaseErr;
  logic signed [WIDTH-1:0] scaledCorr;
  logic signed [WIDTH-1:0] clampedCorr;
  logic [WIDTH-1:0]        candidate;
  logic [WIDTH-1:0]        stagedQ;
  logic [WIDTH-1:0]        stagedSource;
  logic [WIDTH-1:0]        compareQ;

  // Mode-dependent constants.
  always_comb begin
    nominalNow = sel60Hz ? NOM_60_W : NOM_50_W;
    limitNow   = sel60Hz ? LIM_60_S : LIM_50_S;
  end

  // Error, gain and limiter.
  always_comb begin
    phaseErr   = signed'(captureValue - edgePosition);
    scaledCorr = phaseErr >>> GAIN_SHIFT;
    if (scaledCorr > limitNow)       clampedCorr = limitNow;
    else if (scaledCorr < -limitNow) clampedCorr = -limitNow;
    else                             clampedCorr = scaledCorr;
    candidate  = nominalNow + WIDTH'(clampedCorr);
  end

  always_comb stagedSource = strobes.stagedFromNominal ? nominalNow : stagedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedQ  <= NOM_50_W;
      compareQ <= NOM_50_W;
    end else begin
      if (strobes.captureEn)  stagedQ  <= candidate;
      if (strobes.transferEn) compareQ <= stagedSource;
    end
  end

  always_comb comparePeriod = strobes.compareFromNominal ? nominalNow : compareQ;

  always_comb begin
    if (rstN && strobes.captureEn)
      AST_SHIFT_KEEPS_SIGN: assert (scaledCorr[WIDTH-1] == phaseErr[WIDTH-1]); // R4
  end

  AST_STAGED_IN_BAND: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |=> (int'(stagedQ) >= LO_BOUND && int'(stagedQ) <= HI_BOUND)); // R5

  AST_TRANSFER_TAKES_OLD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.transferEn |=> compareQ == $past(stagedSource)); // R8

endmodule

// File: rtl/mainsPeriodCorrector.sv
module mainsPeriodCorrector
  import mainsPeriodPkg::*;
#(
  parameter int WIDTH           = 16,
  parameter int TICKS_50        = 6666,
  parameter int TICKS_60        = 5555,
  parameter int RELOAD_OFFSET   = 5,
  parameter int GAIN_SHIFT      = 4,
  parameter int CLAMP_PER_MILLE = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel60Hz,
  input  logic             captureValid,
  input  logic [WIDTH-1:0] captureValue,
  input  logic [WIDTH-1:0] edgePosition,
  input  logic             cycleStart,
  output logic [WIDTH-1:0] comparePeriod
);

  localparam logic [WIDTH-1:0] RST_50 = WIDTH'(TICKS_50 - RELOAD_OFFSET);
  localparam logic [WIDTH-1:0] RST_60 = WIDTH'(TICKS_60 - RELOAD_OFFSET);

  pcStrobes_t strobeBus;

  mainsPeriodControl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .captureValid (captureValid),
    .cycleStart   (cycleStart),
    .strobes      (strobeBus)
  );

  mainsPeriodDatapath #(
    .WIDTH           (WIDTH),
    .TICKS_50        (TICKS_50),
    .TICKS_60        (TICKS_60),
    .RELOAD_OFFSET   (RELOAD_OFFSET),
    .GAIN_SHIFT      (GAIN_SHIFT),
    .CLAMP_PER_MILLE (CLAMP_PER_MILLE)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .sel60Hz       (sel60Hz),
    .strobes       (strobeBus),
    .captureValue  (captureValue),
    .edgePosition  (edgePosition),
    .comparePeriod (comparePeriod)
  );

  AST_NOMINAL_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobeBus.compareFromNominal |-> comparePeriod == (sel60Hz ? RST_60 : RST_50)); // R1

  AST_HOLD_BETWEEN_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeBus.compareFromNominal && !cycleStart) |=> $stable(comparePeriod)); // R7

endmodule

// File: tb/mainsPeriodCorrector_tb_top.sv
module mainsPeriodCorrector_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel60Hz = 1'b0;
  logic        captureValid = 1'b0;
  logic [15:0] captureValue = '0;
  logic [15:0] edgePosition = '0;
  logic        cycleStart = 1'b0;
  logic [15:0] comparePeriod;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Scoreboard queue: expected compare value and requirement tag.
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        xferSeenQ = 1'b0;

  // Bench-side model of the staging register.
  logic [15:0] mStaged;
  bit          mHasCapture = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mainsPeriodCorrector dut_i (
    .clk           (clk),
    .rstN          (rstN),
    .sel60Hz       (sel60Hz),
    .captureValid  (captureValid),
    .captureValue  (captureValue),
    .edgePosition  (edgePosition),
    .cycleStart    (cycleStart),
    .comparePeriod (comparePeriod)
  );

  function automatic logic [15:0] nominalOf(input logic s60);
    return s60 ? 16'd5550 : 16'd6661;
  endfunction

  function automatic logic [15:0] modelPeriod(input logic [15:0] cap, input logic [15:0] edgeP,
                                              input logic s60);
    logic [15:0] diff;
    int err, sc, lim;
    diff = cap - edgeP;
    err  = int'($signed(diff));
    sc   = err >>> 4;
    lim  = s60 ? 27 : 33;
    if (sc > lim)  sc = lim;
    if (sc < -lim) sc = -lim;
    return 16'(int'(nominalOf(s60)) + sc);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver tasks: signals change on the falling edge only.
  task automatic doCapture(input logic [15:0] cap, input logic [15:0] edgeP);
    captureValue = cap;
    edgePosition = edgeP;
    captureValid = 1'b1;
    mStaged      = modelPeriod(cap, edgeP, sel60Hz);
    mHasCapture  = 1;
    @(negedge clk);
    captureValid = 1'b0;
  endtask

  task automatic doTransfer(input string tag);
    expQ.push_back(mHasCapture ? mStaged : nominalOf(sel60Hz));
    tagQ.push_back(tag);
    cycleStart = 1'b1;
    @(negedge clk);
    cycleStart = 1'b0;
    @(negedge clk);
  endtask

  // R8: capture and transfer in the same cycle; transfer expects the old staged value.
  task automatic doBoth(input logic [15:0] cap, input logic [15:0] edgeP, input string tag);
    expQ.push_back(mHasCapture ? mStaged : nominalOf(sel60Hz));
    tagQ.push_back(tag);
    captureValue = cap;
    edgePosition = edgeP;
    captureValid = 1'b1;
    cycleStart   = 1'b1;
    mStaged      = modelPeriod(cap, edgeP, sel60Hz);
    mHasCapture  = 1;
    @(negedge clk);
    captureValid = 1'b0;
    cycleStart   = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compares the output after each cycle-start edge.
  always @(posedge clk) xferSeenQ <= cycleStart;

  always @(negedge clk) begin
    if (xferSeenQ) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R7: actual=%0d expected=<none queued>", comparePeriod);
      end else begin
        check(tagQ.pop_front(), comparePeriod, expQ.pop_front());
      end
    end
  end

  task automatic finishRun();
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R7: actual=%0d pending expected=%0d", 0, expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1/R2: nominal follows the mode before any transfer.
    check("R1 reset 50Hz nominal", comparePeriod, 16'd6661);
    sel60Hz = 1'b1;
    #1;
    check("R2 60Hz nominal", comparePeriod, 16'd5550);

    // R9: transfer with no capture loads the current mode's nominal.
    doTransfer("R9 transfer without capture");
    sel60Hz = 1'b0;
    #1;
    check("R7 mode change after load holds", comparePeriod, 16'd5550);

    // R6: zero error.
    doCapture(16'd1000, 16'd1000);
    check("R7 capture alone does not change output", comparePeriod, 16'd5550);
    doTransfer("R6 zero error");

    // R6 positive error 160 -> +10.
    doCapture(16'd1160, 16'd1000);
    @(negedge clk);
    check("R7 output held until cycle start", comparePeriod, 16'd6661);
    doTransfer("R6 error +160");

    // R4: rounding toward minus infinity.
    doCapture(16'd999, 16'd1000);   doTransfer("R4 error -1");
    doCapture(16'd1015, 16'd1000);  doTransfer("R4 error +15");
    doCapture(16'd983, 16'd1000);   doTransfer("R4 error -17");

    // R5: 50 Hz clamp edges.
    doCapture(16'd1528, 16'd1000);  doTransfer("R5 exactly +33");
    doCapture(16'd1544, 16'd1000);  doTransfer("R5 one past +33");
    doCapture(16'd2000, 16'd1000);  doTransfer("R5 far positive");
    doCapture(16'd0, 16'd1000);     doTransfer("R5 far negative");
    doCapture(16'd472, 16'd1000);   doTransfer("R5 exactly -33");

    // R5/R6: 60 Hz limits.
    sel60Hz = 1'b1;
    doCapture(16'd2000, 16'd1000);  doTransfer("R5 60Hz positive clamp");
    doCapture(16'd0, 16'd1000);     doTransfer("R5 60Hz negative clamp");
    doCapture(16'd1432, 16'd1000);  doTransfer("R6 60Hz within limit");
    sel60Hz = 1'b0;

    // R3: wrapped subtraction.
    doCapture(16'd10, 16'd65530);   doTransfer("R3 wrap positive");
    doCapture(16'd65530, 16'd10);   doTransfer("R3 wrap negative");

    // R8: simultaneous capture and cycle start.
    doCapture(16'd1320, 16'd1000);
    doBoth(16'd680, 16'd1000, "R8 simultaneous takes old value");
    doTransfer("R8 new value at next start");

    // R9: last of several captures wins.
    doCapture(16'd1100, 16'd1000);
    doCapture(16'd1200, 16'd1000);
    doCapture(16'd920, 16'd1000);
    doTransfer("R9 last capture wins");

    repeat (3) @(negedge clk);
    done = 1;
    finishRun();
  end

endmodule